// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Coherent Seconds Capture

This block keeps elapsed time as two counters on a small memory-mapped register bus. A seconds count and a milliseconds count (0 to 999) advance on a once-per-millisecond tick pulse. The tick comes from a slow always-on clock domain, so the counter keeps running while the rest of the system sleeps. Software composes a wrapping 32-bit time as seconds times 1000 plus milliseconds.

Reading the two counters with two separate bus reads could tear: the milliseconds may roll over between the two reads. To prevent this, a read of the milliseconds register copies the live seconds count into a shadow register at the same clock edge. Software reads milliseconds first and the shadow second, and so always gets a matching pair. Writing the live seconds register loads a new time and restarts the millisecond phase at zero.

Top module: `rtc_ms_shadow`

## Requirements
- R1: After reset is released, the live seconds, shadow seconds and milliseconds registers all read 0.
- R2: A clock cycle with tick_i high and no seconds write raises the millisecond count by one when it is below 999. A cycle without tick and without a seconds write leaves both counters unchanged.
- R3: A tick while the millisecond count is 999 sets milliseconds to 0 and increments seconds at the same clock edge.
- R4: Seconds wrap from all ones to 0 on a rollover.
- R5: A read at byte address 0x10 returns the live millisecond count combinationally in the same cycle. At that edge the shadow register takes the seconds value from before that edge, so a read that coincides with a rollover yields the pair (S, 999).
- R6: The shadow register changes only on a millisecond read. Ticks, rollovers, seconds writes and reads of other addresses leave it unchanged.
- R7: A write at byte address 0x08 loads seconds from bus_wdata_i and clears milliseconds to 0 at the next edge. It takes priority over a tick in the same cycle.
- R8: Writes to 0x0C (shadow), 0x10 (milliseconds) or any unmapped address change no register. Reads of unmapped addresses return 0.
- R9: A read at 0x08 returns the live seconds count. A read at 0x0C returns the shadow seconds. Neither read changes any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per elapsed millisecond |
| bus_valid_i | input | 1 | Bus access in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the current address |

## Verification
Two pairs of functions can land on the same edge. The first is a millisecond read and the 999-to-0 rollover. The bench steps the counter to 999 without reading and then issues the millisecond read in the tick cycle. It judges the result by the returned 999 and by a shadow that still holds the old seconds while the live seconds have advanced. The second is a seconds write and a tick. The bench drives both at once and expects the loaded value with milliseconds at zero, not at one. A bench model updated on every edge predicts every read, including the whole 999-tick sweeps across second boundaries and the wrap of seconds.

// File: rtl/rtc_ms_shadow_pkg.sv
package rtc_ms_shadow_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_SEC    = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_SHADOW = 8'h0C;
  localparam logic [ADDR_W-1:0] ADDR_MSEC   = 8'h10;

  typedef struct packed {
    logic wr_sec;
    logic rd_sec;
    logic rd_shadow;
    logic rd_msec;
  } access_t;
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
  import rtc_ms_shadow_pkg::*;
(
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output access_t           acc_o
);
  logic rd, wr;

  assign rd = valid_i && !write_i;
  assign wr = valid_i &&  write_i;

  always_comb begin
    acc_o           = '0;
    acc_o.wr_sec    = wr && (addr_i == ADDR_SEC);
    acc_o.rd_sec    = rd && (addr_i == ADDR_SEC);
    acc_o.rd_shadow = rd && (addr_i == ADDR_SHADOW);
    acc_o.rd_msec   = rd && (addr_i == ADDR_MSEC);
  end
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned MS_PER_SEC = 1000,
  localparam int unsigned MS_W      = $clog2(MS_PER_SEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_val_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [MS_W-1:0]  ms_o
);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

  logic [SEC_W-1:0] sec_q;
  logic [MS_W-1:0]  ms_q;
  logic             wrap;

  assign wrap = (ms_q == MS_LAST);

  // load beats tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      ms_q  <= '0;
    end else if (load_i) begin
      sec_q <= load_val_i;
      ms_q  <= '0;
    end else if (tick_i) begin
      if (wrap) begin
        ms_q  <= '0;
        sec_q <= sec_q + 1'b1;
      end else begin
        ms_q  <= ms_q + 1'b1;
      end
    end
  end

  assign sec_o = sec_q;
  assign ms_o  = ms_q;
endmodule

// File: rtl/rtc_shadow_latch.sv
module rtc_shadow_latch #(
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [SEC_W-1:0] sec_i,
  output logic [SEC_W-1:0] shadow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        shadow_o <= '0;
    else if (capture_i) shadow_o <= sec_i;
  end
endmodule

// File: rtl/rtc_ms_shadow.sv
module rtc_ms_shadow
  import rtc_ms_shadow_pkg::*;
#(
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned MS_PER_SEC = 1000,
  parameter int unsigned DATA_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o
);
  localparam int unsigned MS_W = $clog2(MS_PER_SEC);

  access_t          acc;
  logic [SEC_W-1:0] sec_q;
  logic [SEC_W-1:0] shadow_q;
  logic [MS_W-1:0]  ms_q;

  rtc_bus_decode u_dec (
    .valid_i (bus_valid_i),
    .write_i (bus_write_i),
    .addr_i  (bus_addr_i),
    .acc_o   (acc)
  );

  rtc_time_counter #(.SEC_W(SEC_W), .MS_PER_SEC(MS_PER_SEC)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (acc.wr_sec),
    .load_val_i (bus_wdata_i[SEC_W-1:0]),
    .sec_o      (sec_q),
    .ms_o       (ms_q)
  );

  rtc_shadow_latch #(.SEC_W(SEC_W)) u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (acc.rd_msec),
    .sec_i     (sec_q),
    .shadow_o  (shadow_q)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (acc.rd_sec)    bus_rdata_o = DATA_W'(sec_q);
    if (acc.rd_shadow) bus_rdata_o = DATA_W'(shadow_q);
    if (acc.rd_msec)   bus_rdata_o = DATA_W'(ms_q);
  end
endmodule

// File: rtl/rtc_ms_shadow_chk.sv
module rtc_ms_shadow_chk
  import rtc_ms_shadow_pkg::*;
#(
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned MS_PER_SEC = 1000,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned MS_W      = $clog2(MS_PER_SEC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [SEC_W-1:0]  sec_q,
  input logic [SEC_W-1:0]  shadow_q,
  input logic [MS_W-1:0]   ms_q
);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

  logic wr_sec, rd_ms;
  assign wr_sec = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_SEC);
  assign rd_ms  = bus_valid_i && !bus_write_i && (bus_addr_i == ADDR_MSEC);

  assert_ms_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_q <= MS_LAST);

  assert_ms_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_sec && ms_q != MS_LAST)
      |=> (ms_q == MS_W'($past(ms_q) + 1'b1)) && $stable(sec_q));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_sec) |=> $stable(ms_q) && $stable(sec_q));

  assert_rollover_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_sec && ms_q == MS_LAST)
      |=> (ms_q == '0) && (sec_q == SEC_W'($past(sec_q) + 1'b1)));

  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sec |=> (sec_q == $past(bus_wdata_i[SEC_W-1:0])) && (ms_q == '0));

  assert_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ms |=> shadow_q == $past(sec_q));

  assert_ms_rdata_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ms |-> bus_rdata_o == DATA_W'(ms_q));

  assert_shadow_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ms |=> $stable(shadow_q));
endmodule

bind rtc_ms_shadow rtc_ms_shadow_chk #(
  .SEC_W(SEC_W), .MS_PER_SEC(MS_PER_SEC), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .sec_q       (sec_q),
  .shadow_q    (shadow_q),
  .ms_q        (ms_q)
);

// File: tb/tb_rtc_ms_shadow.sv
module tb_rtc_ms_shadow;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] m_sec = '0;
  logic [31:0] m_sh  = '0;
  int          m_ms  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_ms_shadow dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .bus_valid_i (valid),
    .bus_write_i (write),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check comb read before edge, update model at edge
  task automatic cyc(input bit t, input bit v, input bit w, input logic [7:0] a,
                     input logic [31:0] d, input string req);
    logic [31:0] exp;
    @(negedge clk);
    tick = t; valid = v; write = w; addr = a; wdata = d;
    #1;
    if (v && !w) begin
      case (a)
        8'h08:   exp = m_sec;
        8'h0C:   exp = m_sh;
        8'h10:   exp = 32'(m_ms);
        default: exp = '0;
      endcase
      check(rdata === exp, req, rdata, exp);
    end
    @(posedge clk);
    if (v && !w && a == 8'h10) m_sh = m_sec;
    if (v && w && a == 8'h08) begin
      m_sec = d; m_ms = 0;
    end else if (t) begin
      if (m_ms == 999) begin m_ms = 0; m_sec = m_sec + 1; end
      else m_ms = m_ms + 1;
    end
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    cyc(1'b0, 1'b1, 1'b0, a, '0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h08, "R1 sec");
    rd(8'h0C, "R1 shadow");
    rd(8'h10, "R1 ms");

    // R2 R3 R5: continuous ticks with ms read every cycle across two rollovers
    for (int i = 0; i < 2500; i++) cyc(1'b1, 1'b1, 1'b0, 8'h10, '0, "R2 R3 R5 sweep");
    rd(8'h0C, "R5 shadow after sweep");
    rd(8'h08, "R9 sec after sweep");

    // R2 hold with no tick
    for (int i = 0; i < 5; i++) rd(8'h10, "R2 hold ms");
    rd(8'h08, "R2 hold sec");

    // R7 write with simultaneous tick: load wins
    cyc(1'b1, 1'b1, 1'b1, 8'h08, 32'hFFFF_FFFE, "R7 load");
    rd(8'h10, "R7 ms cleared");
    rd(8'h08, "R7 sec loaded");
    rd(8'h0C, "R6 shadow unchanged by write");

    // R4 wrap of seconds
    for (int i = 0; i < 2000; i++) cyc(1'b1, 1'b0, 1'b0, '0, '0, "R4 ticks");
    rd(8'h08, "R4 sec wrapped");
    rd(8'h10, "R4 ms");

    // R3 R5 collision: read ms in the rollover cycle
    cyc(1'b0, 1'b1, 1'b1, 8'h08, 32'd5, "R7 load 5");
    for (int i = 0; i < 999; i++) cyc(1'b1, 1'b0, 1'b0, '0, '0, "R3 ticks");
    cyc(1'b1, 1'b1, 1'b0, 8'h10, '0, "R5 ms=999 at rollover");
    check(m_sh == 32'd5, "R5 model", m_sh, 32'd5);
    rd(8'h0C, "R5 shadow old sec");
    rd(8'h08, "R3 sec incremented");
    rd(8'h10, "R3 ms zero");

    // R6 shadow holds over ticks and other reads
    for (int i = 0; i < 1200; i++) cyc(1'b1, 1'b1, 1'b0, (i % 2 == 0) ? 8'h08 : 8'h0C, '0, "R6 R9 reads");
    rd(8'h0C, "R6 shadow held");

    // R8 ignored writes and unmapped reads
    cyc(1'b0, 1'b1, 1'b1, 8'h0C, 32'h1234_5678, "R8 wr shadow");
    cyc(1'b0, 1'b1, 1'b1, 8'h10, 32'h0000_0123, "R8 wr ms");
    cyc(1'b0, 1'b1, 1'b1, 8'h04, 32'hDEAD_BEEF, "R8 wr unmapped");
    rd(8'h0C, "R8 shadow kept");
    rd(8'h08, "R8 sec kept");
    rd(8'h10, "R8 ms kept");
    rd(8'h00, "R8 unmapped 00");
    rd(8'h14, "R8 unmapped 14");
    rd(8'h09, "R8 unmapped 09");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule